// File: doc/BRIEF.md
# Serial Receive Frame Buffer with Per-Entry Status

This block sits between the deserializer of an asynchronous serial receiver and the host. Each time the deserializer finishes a frame it presents eight data bits, an optional ninth data bit and a framing-error flag for one clock. The block keeps those frames in a small circular FIFO (two entries by default). Every entry carries its own status bits beside its byte, so the status the host sees always belongs to the frame it is about to take.

The host inspects the status outputs, which show the oldest stored entry, and then issues a read request. The read pops that entry and captures its byte into a read-data register. Once popped, the entry's status is gone. This is why the status must be looked at before the byte is taken.

When every FIFO entry is occupied, one more finished frame is parked in a holding stage that stands in for the receiver's shift register. No data is lost until the deserializer reports the start bit of yet another frame while the FIFO is still full. Only then is the parked frame thrown away. An overrun mark is then attached to the next frame that enters the FIFO. If a read frees an entry first, the parked frame moves into the FIFO on the following clock.

Top module: `uart_rx_fifo`

## Requirements
- R1: Frames are returned in arrival order, the FIFO never holds more than DEPTH entries, and `rdy` is high exactly while at least one entry is stored. A frame written into an empty FIFO makes `rdy` high after that same clock edge.
- R2: `st_ferr` and `st_bit9` show the framing-error flag and ninth bit that arrived with the oldest stored frame. They are not taken from the most recent frame.
- R3: A read request while `rdy` is high removes the oldest entry and loads its byte into `rd_byte` at that clock edge.
- R4: While the FIFO is empty, `st_ferr`, `st_bit9` and `st_ovr` are all 0. After a pop, the status outputs switch to the next entry's own bits.
- R5: A frame that completes while the FIFO is full and nothing is parked goes into the holding stage. It is not lost and raises no overrun mark.
- R6: When the FIFO has a free entry and a frame is parked, the parked frame is written into the FIFO at the next clock edge. It keeps its byte and status bits.
- R7: A start-bit indication while a frame is parked, the FIFO is full and no read occurs in that cycle discards the parked frame. If a read occurs in the same cycle, the parked frame survives. A frame completing while another is parked and cannot move also discards the parked one.
- R8: After a frame is discarded, the next entry written into the FIFO has its overrun bit set, shown on `st_ovr` when it is the head. Entries written before the loss, and entries written after the marked one, have the bit clear.
- R9: A read request while the FIFO is empty leaves `rd_byte`, `rdy` and the status outputs unchanged.
- R10: A clock edge with `rst_n` low empties the FIFO, clears the holding stage and the pending overrun mark, and sets `rd_byte` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_valid | input | 1 | One-cycle strobe: a frame has completed |
| frm_data | input | DW | Completed frame's eight data bits |
| frm_bit9 | input | 1 | Completed frame's ninth data bit |
| frm_ferr | input | 1 | Framing error seen on the completed frame |
| start_det | input | 1 | One-cycle strobe: a new start bit was detected |
| rd_req | input | 1 | Host read of the data register (pops the head) |
| rdy | output | 1 | At least one frame is stored |
| rd_byte | output | DW | Byte captured by the latest successful read |
| st_bit9 | output | 1 | Ninth bit of the head entry |
| st_ferr | output | 1 | Framing-error bit of the head entry |
| st_ovr | output | 1 | Overrun bit of the head entry |

## Verification
The hardest case to reach is a frame lost from the holding stage, followed by the overrun mark showing up on the right entry. To get there, the FIFO must be filled, one more frame must be parked, and a start strobe must arrive in a cycle without a read. Reads must then drain the entries that came before the loss. The bench builds this order directly. It also drives the near miss in which the start strobe and a read land in the same cycle. A long stretch of random strobes is then compared every clock against a queue-based model. That stretch also reaches the overlapping cases, such as a parked frame moving while a new one completes.

// File: rtl/uart_rx_fifo_pkg.sv
// Package: shared widths and the stored entry layout for the receive buffer.
// Assumes a frame payload of RXB_DW data bits plus one optional ninth bit.
package uart_rx_fifo_pkg;

    parameter int unsigned RXB_DW = 8;

    // One stored frame: byte plus the status that travels with it.
    typedef struct packed {
        logic [RXB_DW-1:0] data;
        logic              bit9;
        logic              ferr;
        logic              ovr;
    } rxb_ent_t;

    localparam int unsigned RXB_ENT_W = $bits(rxb_ent_t);

endpackage

// File: rtl/rxb_fifo.sv
// Module: rxb_fifo
// Circular FIFO of DEPTH entries with a write pointer, a read pointer and an
// occupancy count. The head entry is presented combinationally.
// Assumes: the caller never writes when full and never pops when empty.
// A simultaneous write and pop keeps the count unchanged.
module rxb_fifo
    import uart_rx_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  rxb_ent_t                         wr_ent,
    input  logic                             rd_en,
    output rxb_ent_t                         head,
    output logic [$clog2(DEPTH+1)-1:0]       count,
    output logic                             empty,
    output logic                             full
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH+1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    rxb_ent_t      slot [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    // Storage: each slot loads when the write pointer selects it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (wr_en && (wr_ptr == PW'(i))) begin
                slot[i] <= wr_ent;
            end
        end
    end

    // Pointer advance with wrap at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_en) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
        end
    end

    // Occupancy tracking from the write and pop strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head presentation and level flags.
    always_comb begin
        head  = slot[rd_ptr];
        empty = (count == '0);
        full  = (count == FULL_CNT);
    end

endmodule

// File: rtl/rxb_hold.sv
// Module: rxb_hold
// Third holding level in front of the FIFO, plus overrun bookkeeping.
// Chooses the FIFO write source each cycle: a parked frame has priority,
// and otherwise a new frame goes straight in when there is room.
// Assumes: start_det and frm_valid are one-cycle strobes from the deserializer.
// fifo_full and pop describe the FIFO as it stands before this clock edge.
module rxb_hold
    import uart_rx_fifo_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frm_valid,
    input  rxb_ent_t frm_ent,
    input  logic     start_det,
    input  logic     pop,
    input  logic     fifo_full,
    output logic     hold_v,
    output logic     wr_en,
    output rxb_ent_t wr_ent,
    output logic     lost
);

    rxb_ent_t hold_ent;
    logic     ovr_pend;
    logic     hold_move;
    logic     direct_wr;
    logic     park_new;

    // Write-source selection and loss detection for this cycle.
    always_comb begin
        hold_move = hold_v && !fifo_full;
        direct_wr = frm_valid && !hold_v && !fifo_full;
        park_new  = frm_valid && !direct_wr;
        lost      = hold_v && !hold_move && ((start_det && !pop) || frm_valid);
        wr_en     = hold_move || direct_wr;
        wr_ent    = hold_move ? hold_ent : frm_ent;
        wr_ent.ovr = ovr_pend;
    end

    // Holding stage contents and valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v   <= 1'b0;
            hold_ent <= '0;
        end else if (park_new) begin
            hold_v   <= 1'b1;
            hold_ent <= frm_ent;
        end else if (hold_move || lost) begin
            hold_v   <= 1'b0;
        end
    end

    // Pending overrun mark: set on a loss, consumed by the next FIFO write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_pend <= 1'b0;
        end else if (lost) begin
            ovr_pend <= 1'b1;
        end else if (wr_en) begin
            ovr_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/rxb_rdport.sv
// Module: rxb_rdport
// Host-side view: a read-data register loaded on each pop, and status
// outputs that show the head entry, forced to zero while the FIFO is empty.
// Assumes: pop is only asserted when the FIFO is not empty.
module rxb_rdport
    import uart_rx_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              empty,
    input  rxb_ent_t          head,
    output logic [RXB_DW-1:0] rd_byte,
    output logic              st_bit9,
    output logic              st_ferr,
    output logic              st_ovr
);

    // Read-data capture at each pop; held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_byte <= '0;
        end else if (pop) begin
            rd_byte <= head.data;
        end
    end

    // Head status, masked while nothing is stored.
    always_comb begin
        st_bit9 = !empty && head.bit9;
        st_ferr = !empty && head.ferr;
        st_ovr  = !empty && head.ovr;
    end

endmodule

// File: rtl/uart_rx_fifo.sv
// Module: uart_rx_fifo (top)
// Receive-side frame buffer: holding stage, DEPTH-entry FIFO with per-entry
// status, and the host read port. Reads on an empty FIFO are ignored.
// Assumes: a synchronous active-low reset and a single clock domain.
module uart_rx_fifo
    import uart_rx_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [RXB_DW-1:0] frm_data,
    input  logic              frm_bit9,
    input  logic              frm_ferr,
    input  logic              start_det,
    input  logic              rd_req,
    output logic              rdy,
    output logic [RXB_DW-1:0] rd_byte,
    output logic              st_bit9,
    output logic              st_ferr,
    output logic              st_ovr
);

    localparam int unsigned CW = $clog2(DEPTH+1);

    rxb_ent_t        frm_ent;
    rxb_ent_t        wr_ent;
    rxb_ent_t        head;
    logic            wr_en;
    logic            pop;
    logic            empty;
    logic            full;
    logic            hold_v;
    logic            lost;
    logic [CW-1:0]   fifo_cnt;

    // Incoming frame packing and pop qualification.
    always_comb begin
        frm_ent.data = frm_data;
        frm_ent.bit9 = frm_bit9;
        frm_ent.ferr = frm_ferr;
        frm_ent.ovr  = 1'b0;
        pop          = rd_req && !empty;
        rdy          = !empty;
    end

    rxb_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .frm_ent   (frm_ent),
        .start_det (start_det),
        .pop       (pop),
        .fifo_full (full),
        .hold_v    (hold_v),
        .wr_en     (wr_en),
        .wr_ent    (wr_ent),
        .lost      (lost)
    );

    rxb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_ent (wr_ent),
        .rd_en  (pop),
        .head   (head),
        .count  (fifo_cnt),
        .empty  (empty),
        .full   (full)
    );

    rxb_rdport u_rdport (
        .clk     (clk),
        .rst_n   (rst_n),
        .pop     (pop),
        .empty   (empty),
        .head    (head),
        .rd_byte (rd_byte),
        .st_bit9 (st_bit9),
        .st_ferr (st_ferr),
        .st_ovr  (st_ovr)
    );

endmodule

// File: rtl/uart_rx_fifo_chk.sv
// Module: uart_rx_fifo_chk
// Property checker bound into uart_rx_fifo; observes ports plus the FIFO
// count and the holding-stage valid bit.
module uart_rx_fifo_chk
    import uart_rx_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        frm_valid,
    input logic                        start_det,
    input logic                        rd_req,
    input logic                        rdy,
    input logic [RXB_DW-1:0]           rd_byte,
    input logic                        st_bit9,
    input logic                        st_ferr,
    input logic                        st_ovr,
    input logic [$clog2(DEPTH+1)-1:0]  fifo_cnt,
    input logic                        hold_v
);

    localparam int unsigned CW = $clog2(DEPTH+1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    // R1: occupancy never exceeds the configured depth
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= FULL_CNT);

    // R4: an empty FIFO shows no status
    assert_empty_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> !(st_bit9 || st_ferr || st_ovr));

    // R9: a read on an empty FIFO leaves the read register alone
    assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rdy) |=> $stable(rd_byte));

    // R5: a frame arriving at a full FIFO is parked, not dropped
    assert_park_on_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !hold_v && fifo_cnt == FULL_CNT) |=> (hold_v && rdy));

    // R6: a parked frame enters a FIFO with room on the next edge
    assert_hold_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_v && fifo_cnt < FULL_CNT && !rd_req) |=> (fifo_cnt == $past(fifo_cnt) + 1'b1));

    // R7: start bit while full and parked, without a read, drops the parked frame
    assert_start_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && hold_v && fifo_cnt == FULL_CNT && !rd_req && !frm_valid) |=> !hold_v);

endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frm_valid (frm_valid),
    .start_det (start_det),
    .rd_req    (rd_req),
    .rdy       (rdy),
    .rd_byte   (rd_byte),
    .st_bit9   (st_bit9),
    .st_ferr   (st_ferr),
    .st_ovr    (st_ovr),
    .fifo_cnt  (fifo_cnt),
    .hold_v    (hold_v)
);

// File: tb/uart_rx_fifo_bench.sv
module uart_rx_fifo_bench;

    localparam int DEPTH = 2;

    typedef struct {
        logic [7:0] d;
        logic       b9;
        logic       fe;
        logic       ov;
    } ment_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_valid = 1'b0;
    logic [7:0] frm_data = '0;
    logic       frm_bit9 = 1'b0;
    logic       frm_ferr = 1'b0;
    logic       start_det = 1'b0;
    logic       rd_req = 1'b0;
    logic       rdy;
    logic [7:0] rd_byte;
    logic       st_bit9;
    logic       st_ferr;
    logic       st_ovr;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    uart_rx_fifo #(.DEPTH(DEPTH)) u_uart_rx_fifo (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
        .frm_bit9(frm_bit9), .frm_ferr(frm_ferr), .start_det(start_det),
        .rd_req(rd_req), .rdy(rdy), .rd_byte(rd_byte), .st_bit9(st_bit9),
        .st_ferr(st_ferr), .st_ovr(st_ovr)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference model state
    ment_t      mq[$];
    ment_t      m_hold;
    ment_t      m_w;
    bit         m_hv;
    bit         m_ovp;
    logic [7:0] m_rd;
    int         m_n;
    bit         m_full, m_pop, m_mv, m_lost, m_we;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Model update at every edge, from the inputs alone
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            mq.delete();
            m_hv = 0; m_ovp = 0; m_rd = '0;
        end else begin
            m_n    = mq.size();
            m_full = (m_n == DEPTH);
            m_pop  = rd_req && (m_n > 0);
            m_mv   = m_hv && !m_full;
            m_lost = m_hv && !m_mv && ((start_det && !m_pop) || frm_valid);
            m_we   = 0;
            if (m_mv) begin
                m_w = m_hold; m_we = 1;
            end else if (frm_valid && !m_hv && !m_full) begin
                m_w = '{frm_data, frm_bit9, frm_ferr, 1'b0}; m_we = 1;
            end
            if (m_pop) begin
                m_rd = mq[0].d;
                void'(mq.pop_front());
            end
            if (m_we) begin
                m_w.ov = m_ovp;
                mq.push_back(m_w);
                m_ovp = 0;
            end
            if (m_lost) m_ovp = 1;
            if (frm_valid && !(!m_hv && !m_full && !m_mv)) begin
                m_hold = '{frm_data, frm_bit9, frm_ferr, 1'b0};
                m_hv = 1;
            end else if (m_mv || m_lost) begin
                m_hv = 0;
            end
        end
    end

    // Compare every output against the model away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rdy == (mq.size() > 0), "R1 rdy", rdy, mq.size() > 0);
            chk(rd_byte == m_rd, "R3 rd_byte", rd_byte, m_rd);
            if (mq.size() > 0) begin
                chk(st_ferr == mq[0].fe && st_bit9 == mq[0].b9, "R2 head status",
                    {st_bit9, st_ferr}, {mq[0].b9, mq[0].fe});
                chk(st_ovr == mq[0].ov, "R8 head overrun", st_ovr, mq[0].ov);
            end else begin
                chk({st_bit9, st_ferr, st_ovr} == 3'b000, "R4 empty status",
                    {st_bit9, st_ferr, st_ovr}, 0);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 200000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // One cycle: drive after the falling edge, return at the next falling edge
    task automatic tick(input bit fv, input logic [7:0] d, input bit b9, input bit fe,
                        input bit st, input bit rd);
        #1;
        frm_valid = fv; frm_data = d; frm_bit9 = b9; frm_ferr = fe;
        start_det = st; rd_req = rd;
        @(negedge clk);
    endtask

    task automatic idle();
        tick(0, 8'h00, 0, 0, 0, 0);
    endtask

    task automatic push(input logic [7:0] d, input bit b9, input bit fe);
        tick(1, d, b9, fe, 0, 0);
    endtask

    task automatic rd();
        tick(0, 8'h00, 0, 0, 0, 1);
    endtask

    initial begin
        @(negedge clk);
        repeat (3) idle();
        rst_n = 1'b1;
        // R10: state after reset
        chk(!rdy && rd_byte == 8'h00, "R10 reset state", {rdy, rd_byte}, 0);
        push(8'h5A, 1, 1);
        #1 rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(!rdy && !st_ferr && !st_bit9, "R10 reset empties", rdy, 0);

        // R1/R2/R3/R4: two frames, status per entry, in order
        push(8'h3C, 1, 0);
        chk(rdy == 1'b1, "R1 rdy after write", rdy, 1);
        push(8'hA5, 0, 1);
        chk(st_bit9 && !st_ferr, "R2 head is first frame", {st_bit9, st_ferr}, 2'b10);
        rd();
        chk(rd_byte == 8'h3C, "R3 first pop", rd_byte, 8'h3C);
        chk(!st_bit9 && st_ferr, "R4 status follows new head", {st_bit9, st_ferr}, 2'b01);
        rd();
        chk(rd_byte == 8'hA5 && !rdy, "R1 second pop empties", {rdy, rd_byte}, 8'hA5);

        // R9: read on empty
        rd();
        chk(rd_byte == 8'hA5 && !rdy && !st_ferr, "R9 empty read ignored", rd_byte, 8'hA5);

        // R5/R6: third frame parked, then moved after a pop
        push(8'h11, 0, 0);
        push(8'h22, 0, 0);
        push(8'h77, 1, 1);
        rd();
        chk(rd_byte == 8'h11, "R5 pop while parked", rd_byte, 8'h11);
        idle();
        rd();
        chk(rd_byte == 8'h22 && st_bit9 && st_ferr && !st_ovr, "R6 parked frame moved",
            {rd_byte, st_bit9, st_ferr, st_ovr}, {8'h22, 3'b110});
        rd();
        chk(rd_byte == 8'h77 && !rdy, "R5 parked frame kept", rd_byte, 8'h77);

        // R7/R8: start bit while full and parked drops the parked frame
        push(8'hF0, 0, 0);
        push(8'hF1, 0, 0);
        push(8'hF2, 0, 0);
        tick(0, 8'h00, 0, 0, 1, 0);
        push(8'hF3, 1, 0);
        rd();
        idle();
        chk(!st_ovr, "R8 entry before loss unmarked", st_ovr, 0);
        rd();
        chk(rd_byte == 8'hF1 && st_ovr && st_bit9, "R7 dropped frame skipped",
            {rd_byte, st_ovr}, {8'hF1, 1'b1});
        rd();
        chk(rd_byte == 8'hF3 && !rdy, "R8 marked frame read", rd_byte, 8'hF3);
        push(8'h44, 0, 0);
        chk(!st_ovr, "R8 mark cleared", st_ovr, 0);
        rd();

        // R7 boundary: start bit and read in the same cycle keep the parked frame
        push(8'hC1, 0, 0);
        push(8'hC2, 0, 0);
        push(8'hC3, 0, 1);
        tick(0, 8'h00, 0, 0, 1, 1);
        chk(rd_byte == 8'hC1, "R7 pop with start", rd_byte, 8'hC1);
        idle();
        rd();
        chk(rd_byte == 8'hC2 && st_ferr && !st_ovr, "R7 parked frame survived",
            {rd_byte, st_ferr, st_ovr}, {8'hC2, 2'b10});
        rd();
        chk(rd_byte == 8'hC3, "R6 survivor read", rd_byte, 8'hC3);

        // Random traffic against the model (all requirements)
        for (int i = 0; i < 3000; i++) begin
            tick(($urandom % 100) < 30, 8'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 100) < 20, ($urandom % 100) < 35);
        end
        idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule